// File: doc/BRIEF.md
# Multi-beat operand address sequencer

This block turns a 6-bit effective-address field and an operand size into a sequence of 32-bit bus beats. The operand is 32, 64 or 96 bits wide. The block works out the base address in one of three ways: from the selected address register, from that register plus a signed 16-bit displacement, or from two extension words. It then issues one beat per 32-bit slice, most significant slice first, at rising addresses. It also handles operands that never reach the bus: a data register operand, or an immediate operand made of extension longs.

For the auto-increment and auto-decrement forms, the block produces the new value for the address register and a write strobe on its own write-back port. The register is adjusted by the size of the whole operand: 4, 8 or 12 bytes. A decrement writes the register back before the first beat and uses the reduced value as the base. An increment uses the old value as the base and writes the register back when the operation completes.

Any combination the block does not support raises a one-cycle illegal-mode pulse. In that case the block starts no beats, writes back no register and gives no completion pulse.

Top module: `ea_beat_seq`

## Requirements
- R1: The field splits into a mode (bits 5:3) and a register number (bits 2:0). Mode 0 is data-register direct and is valid only with op_size 0 (32 bits). It starts no bus beats. A read returns dreg_rdata of the selected register in op_rdata[31:0]. A write pulses dreg_we with op_wdata[31:0] to that register in the completion cycle.
- R2: op_size encodes the width: 0 is 32 bits (1 beat), 1 is 64 bits (2 beats), 2 is 96 bits (3 beats). For a width of n beats, beat k uses address base+4k, and beats are numbered from 0. Beat k carries the operand slice at bits [(n-1-k)*32 +: 32] of op_wdata or op_rdata, so the most significant slice comes first.
- R3: Mode 3 (postincrement) uses the current address register as the base. In the completion cycle it writes the register back as base+4n.
- R4: Mode 4 (predecrement) subtracts 4n from the address register and uses the result as the base. It writes that result back in the first beat cycle, before the first beat completes.
- R5: Mode 5 forms the base as the address register plus the sign-extended 16-bit disp, modulo 2^32. The register is not written back.
- R6: Mode 7 with register 1 is absolute. The address is {ext_words[95:80], ext_words[79:64]}, so the first word gives the upper half.
- R7: Mode 7 with register 4 is an immediate read. It starts no bus beats, and op_rdata[n*32-1:0] takes ext_words[95 -: n*32], with the first long as the most significant slice.
- R8: The following combinations pulse illegal_mode for exactly one cycle, starting the cycle after start, and cause no bus beat, no register write-back and no done: mode 1, mode 6, mode 7 with registers other than 1 and 4, op_size 3, mode 0 with a width other than 32 bits, and an immediate write.
- R9: bus_req stays high with a stable address, direction and write data until bus_ack is sampled high. Each acknowledged beat is consumed once.
- R10: done pulses for one cycle, one cycle after the last beat is acknowledged. After reset, busy, done, bus_req and illegal_mode are all low. A start while busy is ignored.
- R11: Mode 2 (register indirect) uses the address register as the base and does not write it back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (sampled while idle) |
| ea_field | input | 6 | Mode in bits 5:3, register number in bits 2:0 |
| op_size | input | 2 | 0: 32 bits, 1: 64 bits, 2: 96 bits |
| op_write | input | 1 | 1 stores the operand, 0 loads it |
| disp | input | 16 | Signed displacement for mode 5 |
| ext_words | input | 96 | Extension words, first word in the top bits |
| op_wdata | input | 96 | Store operand, right-aligned |
| op_rdata | output | 96 | Load result, right-aligned, valid with done |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal_mode | output | 1 | One-cycle pulse for an unsupported combination |
| areg_sel | output | 3 | Address register read select |
| areg_rdata | input | 32 | Address register read value |
| areg_we | output | 1 | Address register write-back strobe |
| areg_wsel | output | 3 | Address register write-back select |
| areg_wdata | output | 32 | Address register write-back value |
| dreg_sel | output | 3 | Data register read select |
| dreg_rdata | input | 32 | Data register read value |
| dreg_we | output | 1 | Data register write strobe |
| dreg_wsel | output | 3 | Data register write select |
| dreg_wdata | output | 32 | Data register write value |
| bus_req | output | 1 | Beat request, held until acknowledged |
| bus_we | output | 1 | Beat direction, 1 is a write |
| bus_addr | output | 32 | Beat byte address |
| bus_wdata | output | 32 | Beat write data |
| bus_ack | input | 1 | Beat acknowledge |
| bus_rdata | input | 32 | Beat read data, valid with bus_ack |

## Verification
The bench checks the order of the slices and the addresses for 96-bit transfers. A design that put the low slice first, or that stepped by the wrong stride, would land data at the wrong addresses. For predecrement, the bench checks that the write-back comes before the first beat completes and that its value matches the first beat address. A design that adjusted the register after the beats, or by 4 instead of 12, is caught by the register value and the beat log. The bench also checks a negative displacement and a displacement that wraps past 2^32. It checks an absolute address with a non-zero upper word, and immediate operands that must leave the bus idle. Every illegal combination, and a start pulsed while the block is busy, must leave the bus, both register ports and done untouched, so leaked beats or stray pulses show up at the ports.

// File: rtl/ea_seq_pkg.sv
package ea_seq_pkg;
   typedef enum logic [1:0] {K_DREG, K_MEM, K_IMM} kind_t;
   typedef enum logic [1:0] {ADJ_NONE, ADJ_INC, ADJ_DEC} adj_t;
   typedef enum logic [1:0] {B_AREG, B_DISP, B_ABS} bsrc_t;
   typedef enum logic [1:0] {S_IDLE, S_BEAT, S_FIN} st_t;

   localparam logic [2:0] M_DREG = 3'd0;
   localparam logic [2:0] M_IND  = 3'd2;
   localparam logic [2:0] M_PINC = 3'd3;
   localparam logic [2:0] M_PDEC = 3'd4;
   localparam logic [2:0] M_DISP = 3'd5;
   localparam logic [2:0] M_EXT  = 3'd7;
   localparam logic [2:0] X_ABSL = 3'd1;
   localparam logic [2:0] X_IMM  = 3'd4;
endpackage

// File: rtl/ea_seq_decode.sv
module ea_seq_decode
   import ea_seq_pkg::*;
#(
   parameter int MAXB = 3,
   parameter int BIW  = 2
) (
   input  logic [5:0]     ea,
   input  logic [1:0]     size,
   input  logic           wr,
   output logic           illegal,
   output kind_t          kind,
   output adj_t           adj,
   output bsrc_t          bsrc,
   output logic [BIW-1:0] nbeats
);
   logic [2:0] mode;
   logic [2:0] rn;

   assign mode = ea[5:3];
   assign rn   = ea[2:0];

   always_comb begin
      illegal = (int'(size) >= MAXB);
      kind    = K_MEM;
      adj     = ADJ_NONE;
      bsrc    = B_AREG;
      nbeats  = BIW'(size) + BIW'(1);
      case (mode)
         M_DREG: begin
            kind = K_DREG;
            if (size != 2'd0) illegal = 1'b1;
         end
         M_IND:  ;
         M_PINC: adj  = ADJ_INC;
         M_PDEC: adj  = ADJ_DEC;
         M_DISP: bsrc = B_DISP;
         M_EXT: begin
            if (rn == X_ABSL) begin
               bsrc = B_ABS;
            end else if (rn == X_IMM) begin
               kind = K_IMM;
               if (wr) illegal = 1'b1;
            end else begin
               illegal = 1'b1;
            end
         end
         default: illegal = 1'b1;
      endcase
   end
endmodule

// File: rtl/ea_seq_addr.sv
module ea_seq_addr
   import ea_seq_pkg::*;
#(
   parameter int AW     = 32,
   parameter int DW     = 32,
   parameter int DISP_W = 16,
   parameter int BIW    = 2
) (
   input  bsrc_t             bsrc,
   input  adj_t              adj,
   input  logic [AW-1:0]     areg,
   input  logic [DISP_W-1:0] disp,
   input  logic [AW-1:0]     abs_addr,
   input  logic [BIW-1:0]    nbeats,
   output logic [AW-1:0]     base,
   output logic [AW-1:0]     wb_val
);
   localparam int BYTES = DW / 8;

   logic [AW-1:0] step;
   logic [AW-1:0] disp_x;

   assign step   = AW'(nbeats) * AW'(BYTES);
   assign disp_x = {{(AW-DISP_W){disp[DISP_W-1]}}, disp};

   always_comb begin
      case (bsrc)
         B_DISP:  base = areg + disp_x;
         B_ABS:   base = abs_addr;
         default: base = (adj == ADJ_DEC) ? (areg - step) : areg;
      endcase
      wb_val = (adj == ADJ_INC) ? (areg + step) : base;
   end
endmodule

// File: rtl/ea_seq_lane.sv
module ea_seq_lane #(
   parameter int DW   = 32,
   parameter int MAXB = 3,
   parameter int BIW  = 2
) (
   input  logic [MAXB*DW-1:0] wdata,
   input  logic [MAXB*DW-1:0] ext,
   input  logic [BIW-1:0]     nb_now,
   input  logic [BIW-1:0]     nb_q,
   input  logic [BIW-1:0]     idx,
   output logic [DW-1:0]      beat_wdata,
   output logic [MAXB*DW-1:0] imm_val,
   output logic [MAXB-1:0]    slot_en
);
   for (genvar g = 0; g < MAXB; g++) begin : g_slot
      localparam logic [BIW-1:0] GV = BIW'(g);
      assign slot_en[g] = (idx == (nb_q - BIW'(1) - GV));
   end

   always_comb begin
      beat_wdata = '0;
      for (int g = 0; g < MAXB; g++) begin
         if (slot_en[g]) beat_wdata = wdata[g*DW +: DW];
      end
   end

   assign imm_val = ext >> ((MAXB - int'(nb_now)) * DW);
endmodule

// File: rtl/ea_beat_seq.sv
module ea_beat_seq
   import ea_seq_pkg::*;
#(
   parameter int AW     = 32,
   parameter int DW     = 32,
   parameter int MAXB   = 3,
   parameter int DISP_W = 16,
   parameter int RI_W   = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [5:0]          ea_field,
   input  logic [1:0]          op_size,
   input  logic                op_write,
   input  logic [DISP_W-1:0]   disp,
   input  logic [MAXB*DW-1:0]  ext_words,
   input  logic [MAXB*DW-1:0]  op_wdata,
   output logic [MAXB*DW-1:0]  op_rdata,
   output logic                busy,
   output logic                done,
   output logic                illegal_mode,
   output logic [RI_W-1:0]     areg_sel,
   input  logic [AW-1:0]       areg_rdata,
   output logic                areg_we,
   output logic [RI_W-1:0]     areg_wsel,
   output logic [AW-1:0]       areg_wdata,
   output logic [RI_W-1:0]     dreg_sel,
   input  logic [DW-1:0]       dreg_rdata,
   output logic                dreg_we,
   output logic [RI_W-1:0]     dreg_wsel,
   output logic [DW-1:0]       dreg_wdata,
   output logic                bus_req,
   output logic                bus_we,
   output logic [AW-1:0]       bus_addr,
   output logic [DW-1:0]       bus_wdata,
   input  logic                bus_ack,
   input  logic [DW-1:0]       bus_rdata
);
   localparam int EXT_W = MAXB * DW;
   localparam int BIW   = $clog2(MAXB + 1);
   localparam int BYTES = DW / 8;

   if (DW % 8 != 0) begin : g_chk_dw
      $error("ea_beat_seq: DW must be a whole number of bytes");
   end
   if (MAXB < 1 || MAXB > 3) begin : g_chk_maxb
      $error("ea_beat_seq: MAXB must be 1 to 3 to match op_size");
   end
   if (EXT_W < AW) begin : g_chk_ext
      $error("ea_beat_seq: extension words narrower than an address");
   end
   if (RI_W != 3) begin : g_chk_ri
      $error("ea_beat_seq: register number is a 3-bit field");
   end

   logic           dec_ill;
   kind_t          dec_kind;
   adj_t           dec_adj;
   bsrc_t          dec_bsrc;
   logic [BIW-1:0] dec_nb;
   logic [AW-1:0]  base_now;
   logic [AW-1:0]  wbv_now;

   st_t                st_q;
   kind_t              kind_q;
   adj_t               adj_q;
   logic               wr_q;
   logic [RI_W-1:0]    rn_q;
   logic [BIW-1:0]     nb_q;
   logic [BIW-1:0]     idx_q;
   logic [AW-1:0]      base_q;
   logic [AW-1:0]      wbv_q;
   logic [EXT_W-1:0]   wd_q;
   logic [EXT_W-1:0]   rdata_q;
   logic               ill_q;
   logic               wbdec_q;
   logic [DW-1:0]      beat_wd;
   logic [EXT_W-1:0]   imm_val;
   logic [MAXB-1:0]    slot_en;

   ea_seq_decode #(.MAXB(MAXB), .BIW(BIW)) u_dec (
      .ea      (ea_field),
      .size    (op_size),
      .wr      (op_write),
      .illegal (dec_ill),
      .kind    (dec_kind),
      .adj     (dec_adj),
      .bsrc    (dec_bsrc),
      .nbeats  (dec_nb)
   );

   ea_seq_addr #(.AW(AW), .DW(DW), .DISP_W(DISP_W), .BIW(BIW)) u_addr (
      .bsrc     (dec_bsrc),
      .adj      (dec_adj),
      .areg     (areg_rdata),
      .disp     (disp),
      .abs_addr (ext_words[EXT_W-1 -: AW]),
      .nbeats   (dec_nb),
      .base     (base_now),
      .wb_val   (wbv_now)
   );

   ea_seq_lane #(.DW(DW), .MAXB(MAXB), .BIW(BIW)) u_lane (
      .wdata      (wd_q),
      .ext        (ext_words),
      .nb_now     (dec_nb),
      .nb_q       (nb_q),
      .idx        (idx_q),
      .beat_wdata (beat_wd),
      .imm_val    (imm_val),
      .slot_en    (slot_en)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= S_IDLE;
         kind_q  <= K_MEM;
         adj_q   <= ADJ_NONE;
         wr_q    <= 1'b0;
         rn_q    <= '0;
         nb_q    <= '0;
         idx_q   <= '0;
         base_q  <= '0;
         wbv_q   <= '0;
         wd_q    <= '0;
         rdata_q <= '0;
         ill_q   <= 1'b0;
         wbdec_q <= 1'b0;
      end else begin
         ill_q   <= 1'b0;
         wbdec_q <= 1'b0;
         case (st_q)
            S_IDLE: begin
               if (start) begin
                  if (dec_ill) begin
                     ill_q <= 1'b1;
                  end else begin
                     kind_q  <= dec_kind;
                     adj_q   <= dec_adj;
                     wr_q    <= op_write;
                     rn_q    <= ea_field[2:0];
                     nb_q    <= dec_nb;
                     idx_q   <= '0;
                     base_q  <= base_now;
                     wbv_q   <= wbv_now;
                     wd_q    <= op_wdata;
                     wbdec_q <= (dec_adj == ADJ_DEC);
                     st_q    <= (dec_kind == K_MEM) ? S_BEAT : S_FIN;
                     if (dec_kind == K_IMM) begin
                        rdata_q <= imm_val;
                     end else begin
                        rdata_q <= '0;
                        if (dec_kind == K_DREG) rdata_q[DW-1:0] <= dreg_rdata;
                     end
                  end
               end
            end
            S_BEAT: begin
               if (bus_ack) begin
                  if (!wr_q) begin
                     for (int g = 0; g < MAXB; g++) begin
                        if (slot_en[g]) rdata_q[g*DW +: DW] <= bus_rdata;
                     end
                  end
                  if (idx_q == nb_q - BIW'(1)) st_q <= S_FIN;
                  else                         idx_q <= idx_q + BIW'(1);
               end
            end
            default: st_q <= S_IDLE;
         endcase
      end
   end

   assign busy         = (st_q != S_IDLE);
   assign done         = (st_q == S_FIN);
   assign illegal_mode = ill_q;
   assign op_rdata     = rdata_q;
   assign areg_sel     = ea_field[2:0];
   assign dreg_sel     = ea_field[2:0];
   assign bus_req      = (st_q == S_BEAT);
   assign bus_we       = wr_q;
   assign bus_addr     = base_q + AW'(idx_q) * AW'(BYTES);
   assign bus_wdata    = beat_wd;
   assign areg_we      = wbdec_q | (done && adj_q == ADJ_INC);
   assign areg_wsel    = rn_q;
   assign areg_wdata   = wbv_q;
   assign dreg_we      = done && kind_q == K_DREG && wr_q;
   assign dreg_wsel    = rn_q;
   assign dreg_wdata   = wd_q[DW-1:0];

   a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)
                                 && $stable(bus_wdata)));

   a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_ack && idx_q != nb_q - BIW'(1))
      |=> (bus_req && bus_addr == $past(bus_addr) + AW'(BYTES)));

   a_r8_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_mode |-> (!bus_req && !areg_we && !dreg_we && !done && !busy));

   a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r4_dec_wb_first: assert property (@(posedge clk) disable iff (!rst_n)
      (areg_we && adj_q == ADJ_DEC) |-> (bus_req && idx_q == '0 && areg_wdata == bus_addr));

   a_r7_imm_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && kind_q != K_MEM) |-> !bus_req);
endmodule

// File: tb/tb_ea_beat_seq.sv
module tb_ea_beat_seq;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [5:0]  ea_field = '0;
   logic [1:0]  op_size = '0;
   logic        op_write = 1'b0;
   logic [15:0] disp = '0;
   logic [95:0] ext_words = '0;
   logic [95:0] op_wdata = '0;
   logic [95:0] op_rdata;
   logic        busy, done, illegal_mode;
   logic [2:0]  areg_sel, areg_wsel, dreg_sel, dreg_wsel;
   logic [31:0] areg_rdata, areg_wdata, dreg_rdata, dreg_wdata;
   logic        areg_we, dreg_we;
   logic        bus_req, bus_we;
   logic [31:0] bus_addr, bus_wdata;
   logic        bus_ack = 1'b0;
   logic [31:0] bus_rdata = '0;

   logic [31:0] aregs [8];
   logic [31:0] dregs [8];
   logic [31:0] mem [256];

   assign areg_rdata = aregs[areg_sel];
   assign dreg_rdata = dregs[dreg_sel];

   ea_beat_seq dut (
      .clk, .rst_n, .start, .ea_field, .op_size, .op_write, .disp, .ext_words,
      .op_wdata, .op_rdata, .busy, .done, .illegal_mode,
      .areg_sel, .areg_rdata, .areg_we, .areg_wsel, .areg_wdata,
      .dreg_sel, .dreg_rdata, .dreg_we, .dreg_wsel, .dreg_wdata,
      .bus_req, .bus_we, .bus_addr, .bus_wdata, .bus_ack, .bus_rdata
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int nvec = 0, nmis = 0, cyc = 0, lat = 0, lcnt = 0;
   int nbeat, first_ack, last_ack, n_awe, awe_cyc, n_dwe, n_done, done_cyc, n_ill;
   logic [31:0] b_addr [8];
   logic [31:0] b_data [8];
   logic [31:0] awe_val;
   logic [95:0] res;

   task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
      nvec++;
      if (act !== exp) begin
         nmis++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 150000) begin
            nmis++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
            $finish;
         end
      end
   end

   initial begin
      forever begin
         @(negedge clk);
         if (bus_ack) begin
            bus_ack = 1'b0;
         end else if (bus_req) begin
            if (lcnt >= lat) begin
               bus_ack   = 1'b1;
               bus_rdata = mem[bus_addr[9:2]];
               if (bus_we) mem[bus_addr[9:2]] = bus_wdata;
               if (nbeat < 8) begin
                  b_addr[nbeat] = bus_addr;
                  b_data[nbeat] = bus_wdata;
               end
               if (nbeat == 0) first_ack = cyc;
               last_ack = cyc;
               nbeat++;
               lcnt = 0;
            end else begin
               lcnt++;
            end
         end
         if (areg_we) begin
            aregs[areg_wsel] = areg_wdata;
            awe_val = areg_wdata;
            awe_cyc = cyc;
            n_awe++;
         end
         if (dreg_we) begin
            dregs[dreg_wsel] = dreg_wdata;
            n_dwe++;
         end
         if (done) begin
            n_done++;
            done_cyc = cyc;
            res = op_rdata;
         end
         if (illegal_mode) n_ill++;
      end
   end

   task automatic run_op(input logic [5:0] ea, input logic [1:0] sz, input logic wr,
                         input logic [15:0] d, input logic [95:0] ext,
                         input logic [95:0] wd, input bit poke);
      @(negedge clk);
      #1;
      nbeat = 0; n_awe = 0; n_dwe = 0; n_done = 0; n_ill = 0; lcnt = 0;
      first_ack = -1; last_ack = -1; done_cyc = -1; awe_cyc = -1;
      ea_field = ea; op_size = sz; op_write = wr; disp = d; ext_words = ext; op_wdata = wd;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < 80; i++) begin
         if (poke && i < 3) begin
            ea_field = 6'o12;
            start = 1'b1;
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
         #1;
         if ((n_done != 0 || n_ill != 0) && !(poke && i < 3)) break;
      end
      start = 1'b0;
      repeat (3) @(negedge clk);
      #1;
   endtask

   task automatic t_reset;
      chk("R10 reset busy", 96'(busy), 96'd0);
      chk("R10 reset done", 96'(done), 96'd0);
      chk("R10 reset bus_req", 96'(bus_req), 96'd0);
      chk("R8 reset illegal_mode", 96'(illegal_mode), 96'd0);
   endtask

   task automatic t_indirect;
      lat = 2;
      run_op(6'o22, 2'd1, 1'b0, 16'h0, '0, '0, 1'b0);
      chk("R11 beats", 96'(nbeat), 96'd2);
      chk("R2 addr0", 96'(b_addr[0]), 96'h100);
      chk("R2 addr1", 96'(b_addr[1]), 96'h104);
      chk("R2 data", res, {32'h0, 32'hC0DE0040, 32'hC0DE0041});
      chk("R11 no wb", 96'(n_awe), 96'd0);
      chk("R10 done timing", 96'(done_cyc), 96'(last_ack + 1));
      chk("R10 done once", 96'(n_done), 96'd1);
   endtask

   task automatic t_postinc;
      lat = 0;
      run_op(6'o33, 2'd2, 1'b0, 16'h0, '0, '0, 1'b0);
      chk("R3 addr0", 96'(b_addr[0]), 96'h200);
      chk("R3 addr2", 96'(b_addr[2]), 96'h208);
      chk("R2 data96", res, {32'hC0DE0080, 32'hC0DE0081, 32'hC0DE0082});
      chk("R3 wb value", 96'(aregs[3]), 96'h20C);
      chk("R3 wb at done", 96'(awe_cyc), 96'(done_cyc));
      run_op(6'o33, 2'd1, 1'b1, 16'h0, '0, {32'hDEAD0000, 32'h11112222, 32'h33334444}, 1'b0);
      chk("R3 waddr0", 96'(b_addr[0]), 96'h20C);
      chk("R2 wdata0", 96'(b_data[0]), 96'h11112222);
      chk("R2 wdata1", 96'(b_data[1]), 96'h33334444);
      chk("R3 wb64", 96'(aregs[3]), 96'h214);
   endtask

   task automatic t_predec;
      lat = 1;
      run_op(6'o44, 2'd2, 1'b1, 16'h0, '0, {32'hAAAA0001, 32'hBBBB0002, 32'hCCCC0003}, 1'b0);
      chk("R4 wb value", 96'(aregs[4]), 96'h2F4);
      chk("R4 wb before beat", 96'(awe_cyc <= first_ack), 96'd1);
      chk("R4 addr0", 96'(b_addr[0]), 96'h2F4);
      chk("R4 addr2", 96'(b_addr[2]), 96'h2FC);
      chk("R2 pd wdata0", 96'(b_data[0]), 96'hAAAA0001);
      chk("R2 pd wdata2", 96'(b_data[2]), 96'hCCCC0003);
      run_op(6'o44, 2'd0, 1'b0, 16'h0, '0, '0, 1'b0);
      chk("R4 wb32", 96'(aregs[4]), 96'h2F0);
      chk("R4 read32", res, 96'hC0DE00BC);
   endtask

   task automatic t_disp;
      lat = 0;
      run_op(6'o55, 2'd0, 1'b0, 16'hFFF0, '0, '0, 1'b0);
      chk("R5 neg addr", 96'(b_addr[0]), 96'h3E0);
      chk("R5 neg data", res, 96'hC0DE00F8);
      chk("R5 no wb", 96'(n_awe), 96'd0);
      run_op(6'o56, 2'd1, 1'b0, 16'h0010, '0, '0, 1'b0);
      chk("R5 wrap addr0", 96'(b_addr[0]), 96'h8);
      chk("R5 wrap addr1", 96'(b_addr[1]), 96'hC);
   endtask

   task automatic t_abs;
      run_op(6'o71, 2'd1, 1'b0, 16'h0, {16'h0000, 16'h0180, 64'h0}, '0, 1'b0);
      chk("R6 addr0", 96'(b_addr[0]), 96'h180);
      chk("R6 data", res, {32'h0, 32'hC0DE0060, 32'hC0DE0061});
      run_op(6'o71, 2'd0, 1'b1, 16'h0, {16'h1234, 16'h0040, 64'h0}, 96'h5A5A5A5A, 1'b0);
      chk("R6 high word", 96'(b_addr[0]), 96'h12340040);
      chk("R6 wdata", 96'(b_data[0]), 96'h5A5A5A5A);
   endtask

   task automatic t_imm;
      run_op(6'o74, 2'd1, 1'b0, 16'h0, {32'h01234567, 32'h89ABCDEF, 32'h55555555}, '0, 1'b0);
      chk("R7 no bus", 96'(nbeat), 96'd0);
      chk("R7 value64", res, {32'h0, 32'h01234567, 32'h89ABCDEF});
      chk("R7 done", 96'(n_done), 96'd1);
      run_op(6'o74, 2'd2, 1'b0, 16'h0, {32'h01234567, 32'h89ABCDEF, 32'h55555555}, '0, 1'b0);
      chk("R7 value96", res, {32'h01234567, 32'h89ABCDEF, 32'h55555555});
   endtask

   task automatic t_dreg;
      run_op(6'o03, 2'd0, 1'b0, 16'h0, '0, '0, 1'b0);
      chk("R1 read", res, 96'h76543210);
      chk("R1 no bus", 96'(nbeat), 96'd0);
      run_op(6'o05, 2'd0, 1'b1, 16'h0, '0, 96'hFACEB00C, 1'b0);
      chk("R1 write", 96'(dregs[5]), 96'hFACEB00C);
      chk("R1 write once", 96'(n_dwe), 96'd1);
   endtask

   task automatic t_illegal;
      logic [5:0] eas [7] = '{6'o12, 6'o62, 6'o70, 6'o22, 6'o03, 6'o74, 6'o33};
      logic [1:0] szs [7] = '{2'd0, 2'd0, 2'd0, 2'd3, 2'd1, 2'd0, 2'd3};
      logic       wrs [7] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
      logic [31:0] a3;
      for (int k = 0; k < 7; k++) begin
         a3 = aregs[3];
         run_op(eas[k], szs[k], wrs[k], 16'h0, {16'h0, 16'h0100, 64'h0}, '0, 1'b0);
         chk($sformatf("R8 case %0d pulse", k), 96'(n_ill), 96'd1);
         chk($sformatf("R8 case %0d quiet", k), 96'(nbeat + n_awe + n_dwe + n_done), 96'd0);
         chk($sformatf("R8 case %0d areg", k), 96'(aregs[3]), 96'(a3));
      end
   endtask

   task automatic t_busy;
      lat = 3;
      run_op(6'o22, 2'd2, 1'b0, 16'h0, '0, '0, 1'b1);
      chk("R10 busy start ignored", 96'(n_ill), 96'd0);
      chk("R10 beats kept", 96'(nbeat), 96'd3);
      chk("R9 stalled addr2", 96'(b_addr[2]), 96'h108);
      chk("R9 stalled data", res, {32'hC0DE0040, 32'hC0DE0041, 32'hC0DE0042});
      chk("R10 done timing", 96'(done_cyc), 96'(last_ack + 1));
      chk("R10 single done", 96'(n_done), 96'd1);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 32'hC0DE0000 + 32'(i);
      for (int i = 0; i < 8; i++) begin
         aregs[i] = 32'h0;
         dregs[i] = 32'h0;
      end
      aregs[2] = 32'h100; aregs[3] = 32'h200; aregs[4] = 32'h300;
      aregs[5] = 32'h3F0; aregs[6] = 32'hFFFFFFF8;
      dregs[3] = 32'h76543210;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      t_reset();
      t_indirect();
      t_postinc();
      t_predec();
      t_disp();
      t_abs();
      t_imm();
      t_dreg();
      t_illegal();
      t_busy();
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
      $finish;
   end
endmodule